// File: doc/BRIEF.md
# Interrupt source controller

This block is a bank of interrupt sources. Each source is fixed at build time as either level-sensitive or message-style. Every source holds a target server number, a priority and a small set of status bits, and the meaning of those bits depends on the source type. Level sources follow an input line and remember whether their current assertion has already been sent. Message sources take single-cycle event pulses and remember whether an event was refused or arrived while the source was masked. Because of this bookkeeping, an interrupt that a presenter refuses can be offered again later.

A presenter drives three kinds of request into the bank. A reject hands an interrupt back. An end-of-interrupt retires a level interrupt. A resend asks the bank to walk all its sources once, one per cycle, and offer again whatever is eligible. Configuration writes set a source's server and priority. The all-ones priority masks the source.

Deliveries leave through a valid/ready port. Each delivery carries a global interrupt number (base offset plus local index), the server and the priority. When several sources are queued, the lowest index goes first.

Top module: `irq_source_bank`

## Requirements
- R1: A priority of all ones (0xFF with the default 8-bit width) masks a source, and no delivery ever carries that priority. After reset every source is masked, so the reset state is masked with clear status.
- R2: An event on unmasked message source i produces a delivery with number BASE_NUM+i and that source's server and priority. dlv_valid is low one cycle after the event cycle and high two cycles after it. The default build has 8 sources, BASE_NUM 16, message sources at indices 0 to 3 and level sources at indices 4 to 7.
- R3: An event on a masked message source is kept as masked-pending and produces no delivery. A later configuration write with an unmasked priority delivers it once. A write that leaves the source masked does not deliver it.
- R4: A level source delivers once when its input is high, it is unmasked and it is not already marked sent. While it stays marked sent there is no further delivery. The check runs only on an input change, a configuration write to that source, or a resend visit.
- R5: A reject of a message source marks it rejected and it is redelivered at the next resend scan. A reject of a level source clears its sent mark without delivering.
- R6: A resend scan visits the sources in index order starting at 0, one per cycle. A rejected message source that is masked when visited loses its rejected mark and is not delivered, even after a later unmask.
- R7: End-of-interrupt clears the sent mark of a level source. On a message source it has no effect: a following resend delivers nothing.
- R8: Reject and end-of-interrupt numbers outside BASE_NUM to BASE_NUM+NUM_SRC-1 change no source.
- R9: While dlv_valid is high and dlv_ready is low, the delivery fields hold steady. Queued deliveries leave one per handshake, lowest index first.
- R10: Reset clears every queued delivery and every status bit, masks every source and clears its server. The source types are parameters and stay as they are.
- R11: A configuration write that masks a source with a queued delivery works by source type. A message source turns the delivery into masked-pending, and it is delivered on unmask. A level source drops the delivery and clears its sent mark, so the source is checked again on unmask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_level | input | NUM_SRC | Input lines of level sources (ignored on message sources) |
| src_event | input | NUM_SRC | One-cycle event pulses for message sources (ignored on level sources) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Local index of the source written |
| cfg_server | input | SRV_W | New target server |
| cfg_prio | input | PRIO_W | New priority; all ones masks |
| rej_valid | input | 1 | Reject request strobe |
| rej_num | input | NUM_W | Global number being rejected |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Global number being retired |
| resend_req | input | 1 | Start (or restart) a resend scan |
| dlv_valid | output | 1 | A delivery is offered |
| dlv_ready | input | 1 | The presenter takes the delivery |
| dlv_num | output | NUM_W | Global interrupt number of the delivery |
| dlv_server | output | SRV_W | Target server of the delivery |
| dlv_prio | output | PRIO_W | Priority of the delivery |

## Verification
The bench targets the places where the two kinds of status bookkeeping differ. It checks that an end-of-interrupt followed by a resend is silent for a message source but offers a level source again. A design that shared one status model would offer a message source again or lose the level one. It masks sources that have a queued delivery and sources that are marked rejected. Wrong handling there would show up as a delivery carrying the masked priority, a lost message interrupt, or a stale redelivery after unmask. It also sends reject and end-of-interrupt numbers just outside the bank's range, which would wrongly clear marks under a loose decode, and it holds dlv_ready low to catch an offer that changes before it is taken.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

  typedef struct packed {
    logic asserted;   // level: input line currently high
    logic sent;       // level: present assertion already delivered
    logic rejected;   // message: refused by the presenter
    logic mpend;      // message: event seen while masked
  } src_stat_t;

  // True when a global number addresses local source idx of this bank.
  function automatic logic bank_hit(input int unsigned num, input int unsigned base,
                                    input int unsigned cnt, input int unsigned idx);
    return (num >= base) && (num < base + cnt) && ((num - base) == idx);
  endfunction

  // Global number of a local source.
  function automatic int unsigned glob_num(input int unsigned base, input int unsigned idx);
    return base + idx;
  endfunction

endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
  import irq_src_pkg::*;
#(
  parameter int unsigned PRIO_W   = 8,
  parameter int unsigned SRV_W    = 4,
  parameter bit          IS_LEVEL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvl_in,
  input  logic              evt,
  input  logic              cfg_hit,
  input  logic [SRV_W-1:0]  cfg_srv,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic              rej_hit,
  input  logic              eoi_hit,
  input  logic              scan_hit,
  input  logic              take,
  output logic              want_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic [SRV_W-1:0]  srv_o,
  output src_stat_t         stat_o
);

  function automatic logic is_masked(input logic [PRIO_W-1:0] p);
    return &p;
  endfunction

  src_stat_t         st_q, st_d;
  logic [PRIO_W-1:0] prio_q, prio_d;
  logic [SRV_W-1:0]  srv_q, srv_d;
  logic              want_q, want_d;
  logic              lvl_chg;

  assign lvl_chg = lvl_in != st_q.asserted;

  always_comb begin
    st_d   = st_q;
    prio_d = prio_q;
    srv_d  = srv_q;
    want_d = want_q;
    if (take) want_d = 1'b0;
    if (cfg_hit) begin
      prio_d = cfg_prio;
      srv_d  = cfg_srv;
    end
    if (IS_LEVEL) begin
      if (rej_hit || eoi_hit) st_d.sent = 1'b0;
      if (cfg_hit && is_masked(prio_d) && want_d) begin
        want_d     = 1'b0;
        st_d.sent  = 1'b0;
      end
      st_d.asserted = lvl_in;
      if ((cfg_hit || lvl_chg || scan_hit) && st_d.asserted && !st_d.sent
          && !is_masked(prio_d)) begin
        st_d.sent = 1'b1;
        want_d    = 1'b1;
      end
    end else begin
      if (rej_hit) st_d.rejected = 1'b1;
      if (cfg_hit) begin
        if (is_masked(prio_d) && want_d) begin
          want_d     = 1'b0;
          st_d.mpend = 1'b1;
        end else if (!is_masked(prio_d) && st_d.mpend) begin
          st_d.mpend = 1'b0;
          want_d     = 1'b1;
        end
      end
      if (evt) begin
        if (is_masked(prio_d)) st_d.mpend = 1'b1;
        else                   want_d     = 1'b1;
      end
      if (scan_hit && st_d.rejected) begin
        st_d.rejected = 1'b0;
        if (!is_masked(prio_d)) want_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      prio_q <= '1;
      srv_q  <= '0;
      want_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      prio_q <= prio_d;
      srv_q  <= srv_d;
      want_q <= want_d;
    end
  end

  assign want_o = want_q;
  assign prio_o = prio_q;
  assign srv_o  = srv_q;
  assign stat_o = st_q;

endmodule

// File: rtl/irq_src_scan.sv
module irq_src_scan #(
  parameter int unsigned NUM_SRC = 8,
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               busy_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [NUM_SRC-1:0] hit_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SRC - 1);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (busy_q) begin
      if (idx_q == LAST) busy_q <= 1'b0;
      else               idx_q  <= idx_q + 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_hit
    assign hit_o[i] = busy_q && (idx_q == IDX_W'(i));
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;

endmodule

// File: rtl/irq_src_out.sv
module irq_src_out
  import irq_src_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 8,
  parameter int unsigned PRIO_W   = 8,
  parameter int unsigned SRV_W    = 4,
  parameter int unsigned NUM_W    = 12,
  parameter int unsigned BASE_NUM = 16,
  localparam int unsigned IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_SRC-1:0]             want,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_v,
  input  logic [NUM_SRC-1:0][SRV_W-1:0]  srv_v,
  input  logic                           ready,
  output logic [NUM_SRC-1:0]             take,
  output logic                           valid_o,
  output logic [NUM_W-1:0]               num_o,
  output logic [SRV_W-1:0]               srv_o,
  output logic [PRIO_W-1:0]              prio_o
);

  logic             found;
  logic [IDX_W-1:0] gidx;
  logic             load;
  logic             valid_q;
  logic [NUM_W-1:0] num_q;
  logic [SRV_W-1:0] srv_q;
  logic [PRIO_W-1:0] prio_q;

  // Lowest queued index wins.
  always_comb begin
    found = 1'b0;
    gidx  = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (want[i]) begin
        found = 1'b1;
        gidx  = IDX_W'(i);
      end
    end
  end

  assign load = found && (!valid_q || ready);
  assign take = load ? (NUM_SRC'(1) << gidx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      num_q   <= '0;
      srv_q   <= '0;
      prio_q  <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      num_q   <= NUM_W'(glob_num(BASE_NUM, 32'(gidx)));
      srv_q   <= srv_v[gidx];
      prio_q  <= prio_v[gidx];
    end else if (ready) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign num_o   = num_q;
  assign srv_o   = srv_q;
  assign prio_o  = prio_q;

endmodule

// File: rtl/irq_source_bank.sv
module irq_source_bank
  import irq_src_pkg::*;
#(
  parameter int unsigned       NUM_SRC   = 8,
  parameter int unsigned       SRV_W     = 4,
  parameter int unsigned       PRIO_W    = 8,
  parameter int unsigned       NUM_W     = 12,
  parameter int unsigned       BASE_NUM  = 16,
  parameter logic [NUM_SRC-1:0] LEVEL_MAP = 8'hF0,
  localparam int unsigned      IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_level,
  input  logic [NUM_SRC-1:0] src_event,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [SRV_W-1:0]   cfg_server,
  input  logic [PRIO_W-1:0]  cfg_prio,
  input  logic               rej_valid,
  input  logic [NUM_W-1:0]   rej_num,
  input  logic               eoi_valid,
  input  logic [NUM_W-1:0]   eoi_num,
  input  logic               resend_req,
  output logic               dlv_valid,
  input  logic               dlv_ready,
  output logic [NUM_W-1:0]   dlv_num,
  output logic [SRV_W-1:0]   dlv_server,
  output logic [PRIO_W-1:0]  dlv_prio
);

  logic [NUM_SRC-1:0]             cfg_hit;
  logic [NUM_SRC-1:0]             rej_hit;
  logic [NUM_SRC-1:0]             eoi_hit;
  logic [NUM_SRC-1:0]             scan_hit;
  logic [NUM_SRC-1:0]             take;
  logic [NUM_SRC-1:0]             want;
  logic [NUM_SRC-1:0][PRIO_W-1:0] src_prio;
  logic [NUM_SRC-1:0][SRV_W-1:0]  src_srv;
  src_stat_t [NUM_SRC-1:0]        src_stat;
  logic                           scan_busy;
  logic [IDX_W-1:0]               scan_idx;

  irq_src_scan #(.NUM_SRC(NUM_SRC)) scan_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (resend_req),
    .busy_o (scan_busy),
    .idx_o  (scan_idx),
    .hit_o  (scan_hit)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign cfg_hit[i] = cfg_we && (cfg_idx == IDX_W'(i));
    assign rej_hit[i] = rej_valid && bank_hit(32'(rej_num), BASE_NUM, NUM_SRC, i);
    assign eoi_hit[i] = eoi_valid && bank_hit(32'(eoi_num), BASE_NUM, NUM_SRC, i);

    irq_src_slot #(
      .PRIO_W   (PRIO_W),
      .SRV_W    (SRV_W),
      .IS_LEVEL (LEVEL_MAP[i])
    ) slot_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl_in   (src_level[i]),
      .evt      (src_event[i]),
      .cfg_hit  (cfg_hit[i]),
      .cfg_srv  (cfg_server),
      .cfg_prio (cfg_prio),
      .rej_hit  (rej_hit[i]),
      .eoi_hit  (eoi_hit[i]),
      .scan_hit (scan_hit[i]),
      .take     (take[i]),
      .want_o   (want[i]),
      .prio_o   (src_prio[i]),
      .srv_o    (src_srv[i]),
      .stat_o   (src_stat[i])
    );
  end

  irq_src_out #(
    .NUM_SRC  (NUM_SRC),
    .PRIO_W   (PRIO_W),
    .SRV_W    (SRV_W),
    .NUM_W    (NUM_W),
    .BASE_NUM (BASE_NUM)
  ) out_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .want    (want),
    .prio_v  (src_prio),
    .srv_v   (src_srv),
    .ready   (dlv_ready),
    .take    (take),
    .valid_o (dlv_valid),
    .num_o   (dlv_num),
    .srv_o   (dlv_server),
    .prio_o  (dlv_prio)
  );

endmodule

// File: rtl/irq_source_bank_chk.sv
module irq_source_bank_chk
  import irq_src_pkg::*;
#(
  parameter int unsigned        NUM_SRC   = 8,
  parameter int unsigned        SRV_W     = 4,
  parameter int unsigned        PRIO_W    = 8,
  parameter int unsigned        NUM_W     = 12,
  parameter int unsigned        BASE_NUM  = 16,
  parameter logic [NUM_SRC-1:0] LEVEL_MAP = 8'hF0,
  localparam int unsigned       IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           dlv_valid,
  input logic                           dlv_ready,
  input logic [NUM_W-1:0]               dlv_num,
  input logic [SRV_W-1:0]               dlv_server,
  input logic [PRIO_W-1:0]              dlv_prio,
  input logic [NUM_SRC-1:0]             want,
  input logic [NUM_SRC-1:0][PRIO_W-1:0] src_prio,
  input src_stat_t [NUM_SRC-1:0]        src_stat,
  input logic                           scan_busy,
  input logic [IDX_W-1:0]               scan_idx,
  input logic                           resend_req
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SRC - 1);

  AST_DLV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && !dlv_ready |=> dlv_valid && $stable(dlv_num) && $stable(dlv_server) && $stable(dlv_prio)); // R9

  AST_DLV_IN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> (32'(dlv_num) >= BASE_NUM) && (32'(dlv_num) < BASE_NUM + NUM_SRC)); // R2

  AST_DLV_NOT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> !(&dlv_prio)); // R1

  AST_SCAN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    scan_busy && !resend_req && (scan_idx != LAST) |=> scan_busy && (scan_idx == $past(scan_idx) + 1'b1)); // R6

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    AST_QUEUED_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      want[i] |-> !(&src_prio[i])); // R11
    if (LEVEL_MAP[i]) begin : g_lvl
      AST_LVL_QUEUED_SENT: assert property (@(posedge clk) disable iff (!rst_n)
        want[i] |-> src_stat[i].sent); // R4
    end
  end

endmodule

bind irq_source_bank irq_source_bank_chk #(
  .NUM_SRC   (NUM_SRC),
  .SRV_W     (SRV_W),
  .PRIO_W    (PRIO_W),
  .NUM_W     (NUM_W),
  .BASE_NUM  (BASE_NUM),
  .LEVEL_MAP (LEVEL_MAP)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .dlv_valid  (dlv_valid),
  .dlv_ready  (dlv_ready),
  .dlv_num    (dlv_num),
  .dlv_server (dlv_server),
  .dlv_prio   (dlv_prio),
  .want       (want),
  .src_prio   (src_prio),
  .src_stat   (src_stat),
  .scan_busy  (scan_busy),
  .scan_idx   (scan_idx),
  .resend_req (resend_req)
);

// File: tb/irq_source_bank_tb_top.sv
module irq_source_bank_tb_top;

  localparam int MASK = 255;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src_level = '0;
  logic [7:0]  src_event = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [3:0]  cfg_server = '0;
  logic [7:0]  cfg_prio = '0;
  logic        rej_valid = 1'b0;
  logic [11:0] rej_num = '0;
  logic        eoi_valid = 1'b0;
  logic [11:0] eoi_num = '0;
  logic        resend_req = 1'b0;
  logic        dlv_valid;
  logic        dlv_ready = 1'b0;
  logic [11:0] dlv_num;
  logic [3:0]  dlv_server;
  logic [7:0]  dlv_prio;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_source_bank dut_i (
    .clk(clk), .rst_n(rst_n), .src_level(src_level), .src_event(src_event),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_server(cfg_server), .cfg_prio(cfg_prio),
    .rej_valid(rej_valid), .rej_num(rej_num), .eoi_valid(eoi_valid), .eoi_num(eoi_num),
    .resend_req(resend_req), .dlv_valid(dlv_valid), .dlv_ready(dlv_ready),
    .dlv_num(dlv_num), .dlv_server(dlv_server), .dlv_prio(dlv_prio)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; src_level = '0; src_event = '0; cfg_we = 1'b0;
    rej_valid = 1'b0; eoi_valid = 1'b0; resend_req = 1'b0; dlv_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg(input int idx, input int srv, input int prio);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_server = 4'(srv); cfg_prio = 8'(prio);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic evt(input int i);
    src_event[i] = 1'b1;
    @(negedge clk);
    src_event = '0;
  endtask

  task automatic reject(input int num);
    rej_valid = 1'b1; rej_num = 12'(num);
    @(negedge clk);
    rej_valid = 1'b0;
  endtask

  task automatic eoi(input int num);
    eoi_valid = 1'b1; eoi_num = 12'(num);
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  task automatic resend();
    resend_req = 1'b1;
    @(negedge clk);
    resend_req = 1'b0;
  endtask

  task automatic take_dlv(input int num, input int srv, input int prio, input string tag);
    int w = 0;
    while (!dlv_valid && w < 40) begin
      @(negedge clk);
      w++;
    end
    chk(dlv_valid == 1'b1, tag, "delivery offered", int'(dlv_valid), 1);
    if (dlv_valid) begin
      chk(int'(dlv_num) == num, tag, "number", int'(dlv_num), num);
      chk(int'(dlv_server) == srv, tag, "server", int'(dlv_server), srv);
      chk(int'(dlv_prio) == prio, tag, "priority", int'(dlv_prio), prio);
      dlv_ready = 1'b1;
      @(negedge clk);
      dlv_ready = 1'b0;
    end
  endtask

  task automatic quiet(input int n, input string tag);
    bit seen = 1'b0;
    repeat (n) begin
      @(negedge clk);
      if (dlv_valid) seen = 1'b1;
    end
    chk(!seen, tag, "no delivery", int'(seen), 0);
  endtask

  // R10 and R3: reset state, masked-pending, pending cleared by reset
  task automatic t_reset_and_mask();
    do_reset();
    chk(dlv_valid == 1'b0, "R10", "valid after reset", int'(dlv_valid), 0);
    evt(1);
    quiet(6, "R3 masked event held");
    do_reset();
    cfg(1, 2, 2);
    quiet(6, "R10 pending cleared by reset");
    evt(0);
    quiet(6, "R1 masked source silent");
    cfg(0, 3, MASK);
    quiet(6, "R3 still masked write");
    cfg(0, 3, 5);
    take_dlv(16, 3, 5, "R3 unmask delivers");
    quiet(6, "R3 delivered once");
  endtask

  // R2: exact latency and number
  task automatic t_message();
    do_reset();
    cfg(2, 1, 4);
    src_event[2] = 1'b1;
    @(negedge clk);
    src_event = '0;
    chk(dlv_valid == 1'b0, "R2", "valid one cycle after event", int'(dlv_valid), 0);
    @(negedge clk);
    chk(dlv_valid == 1'b1, "R2", "valid two cycles after event", int'(dlv_valid), 1);
    take_dlv(18, 1, 4, "R2");
  endtask

  // R4 and R5 (level part)
  task automatic t_level();
    do_reset();
    cfg(4, 2, 3);
    quiet(6, "R4 low input silent");
    src_level[4] = 1'b1;
    take_dlv(20, 2, 3, "R4 rising input");
    quiet(10, "R4 held high no repeat");
    eoi(20);
    quiet(10, "R4 no recheck without event");
    resend();
    take_dlv(20, 2, 3, "R4 resend after eoi");
    src_level[4] = 1'b0;
    @(negedge clk);
    eoi(20);
    resend();
    quiet(16, "R4 low input not resent");
    src_level[4] = 1'b1;
    take_dlv(20, 2, 3, "R4 second assertion");
    reject(20);
    quiet(6, "R5 level reject silent");
    cfg(4, 2, 3);
    take_dlv(20, 2, 3, "R5 level reject then write");
  endtask

  // R5, R6, R9 order
  task automatic t_reject_resend();
    do_reset();
    cfg(0, 1, 5);
    cfg(1, 2, 6);
    src_event[0] = 1'b1; src_event[1] = 1'b1;
    @(negedge clk);
    src_event = '0;
    take_dlv(16, 1, 5, "R9 lowest first");
    take_dlv(17, 2, 6, "R9 second");
    reject(16);
    reject(17);
    quiet(6, "R5 message reject silent");
    cfg(1, 2, MASK);
    resend();
    take_dlv(16, 1, 5, "R5 redelivered by resend");
    quiet(16, "R6 masked rejected dropped");
    cfg(1, 2, 6);
    quiet(6, "R6 no stale redelivery");
  endtask

  // R7: eoi on message source has no effect
  task automatic t_eoi_message();
    do_reset();
    cfg(2, 1, 4);
    evt(2);
    take_dlv(18, 1, 4, "R7 setup");
    eoi(18);
    resend();
    quiet(16, "R7 message eoi no effect");
  endtask

  // R8: out-of-range numbers
  task automatic t_range();
    do_reset();
    cfg(0, 1, 5);
    evt(0);
    take_dlv(16, 1, 5, "R8 setup");
    reject(24);
    reject(15);
    resend();
    quiet(16, "R8 out of range reject");
    cfg(4, 1, 3);
    src_level[4] = 1'b1;
    take_dlv(20, 1, 3, "R8 level setup");
    eoi(24);
    eoi(15);
    resend();
    quiet(16, "R8 out of range eoi");
    eoi(20);
    resend();
    take_dlv(20, 1, 3, "R8 in range eoi");
  endtask

  // R9: fields held while not ready
  task automatic t_hold();
    bit stable = 1'b1;
    do_reset();
    cfg(0, 1, 5);
    cfg(3, 2, 7);
    src_event[0] = 1'b1; src_event[3] = 1'b1;
    @(negedge clk);
    src_event = '0;
    @(negedge clk);
    repeat (5) begin
      @(negedge clk);
      if (!dlv_valid || dlv_num != 12'd16 || dlv_prio != 8'd5) stable = 1'b0;
    end
    chk(stable, "R9", "offer held while not ready", int'(stable), 1);
    take_dlv(16, 1, 5, "R9 held offer");
    take_dlv(19, 2, 7, "R9 next queued");
  endtask

  // R11: masking a queued delivery
  task automatic t_mask_queued();
    do_reset();
    cfg(0, 1, 5);
    cfg(1, 1, 4);
    evt(0);
    evt(1);
    cfg(1, 1, MASK);
    take_dlv(16, 1, 5, "R11 head");
    quiet(6, "R11 masked queued message held");
    cfg(1, 1, 4);
    take_dlv(17, 1, 4, "R11 message unmask delivers");
    do_reset();
    cfg(4, 0, 3);
    cfg(5, 0, 2);
    src_level[4] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    src_level[5] = 1'b1;
    @(negedge clk);
    cfg(5, 0, MASK);
    take_dlv(20, 0, 3, "R11 level head");
    quiet(6, "R11 masked queued level dropped");
    cfg(5, 0, 2);
    take_dlv(21, 0, 2, "R11 level unmask rechecks");
  endtask

  initial begin
    t_reset_and_mask();
    t_message();
    t_level();
    t_reject_resend();
    t_eoi_message();
    t_range();
    t_hold();
    t_mask_queued();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule